// File: doc/BRIEF.md
# Switchable-Rate Digital Delay Line

This block is the memory stage of a surround effect path. An upstream converter supplies signed samples over a valid/ready stream. For each sample it accepts, the block returns exactly one sample over a second valid/ready stream. That output sample is taken from a circular buffer at a tap chosen by a 3-bit delay code. The code selects one of six equally spaced tap lengths. In fast mode every accepted sample is stored. In slow mode only the first sample of each pair is stored, and its tapped output is repeated on both outputs of the pair. The same buffer therefore spans twice the time at the same stream rate.

An optional feedback path adds half of the tapped sample back into the value that is stored, which gives reverb. An input mute replaces the incoming sample with silence before the feedback sum. A system-mute input starts a sweep that writes zero to every location and returns the write position to zero. This stops stale contents from being replayed after a change of tap or rate. The same sweep runs after reset.

Back-pressure rules: `s_ready` is high whenever the output register is empty or is being drained in the same cycle. While `m_valid` is high and `m_ready` is low, the block accepts nothing and holds `m_data`. The configuration pins are plain levels, sampled every cycle.

Top module: `dl_delay_line`

## Requirements
- R1: After reset a zero-fill sweep of all DEPTH locations runs for DEPTH cycles. Right after reset `m_valid` is 0 and `s_ready` is 1. Samples accepted during the sweep produce 0 at the output and are not stored.
- R2: In fast mode (`cfg_slow`=0), each accepted sample is stored. The output is the value stored K*STEP accepted samples earlier, where STEP = DEPTH/6 and K = code+1 for the binary code values 0 to 5 on `cfg_delay_code`.
- R3: In slow mode (`cfg_slow`=1), only the first sample of each accepted pair is stored. The first output of a pair is the value stored K*STEP stores earlier, and the second output of the pair repeats it.
- R4: The delay codes 6 and 7 are ignored, and the tap in effect before them stays in effect.
- R5: With `cfg_feedback`=1, the stored value is the input plus the tapped sample shifted right by one bit, arithmetic, so it rounds toward minus infinity.
- R6: With `cfg_in_mute`=1, the input term of the stored value is zero. The feedback term still applies.
- R7: A rising edge on `sys_mute` restarts the zero-fill sweep and resets the write position and the pair phase. While `sys_mute` is high or the sweep runs, outputs are 0 and nothing is stored. After the sweep, every tap reads 0 until it is overwritten.
- R8: `s_ready` = !`m_valid` || `m_ready`. Every accepted input raises `m_valid` on the next cycle. While `m_valid` is high and `m_ready` is low, `m_data` is held.
- R9: The stored sum saturates to the signed W-bit range: 32767 and -32768 at W=16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can take a sample |
| s_data | input | W | Signed input sample |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Downstream can take a sample |
| m_data | output | W | Signed delayed sample |
| cfg_delay_code | input | 3 | Tap code, 0..5 gives K=1..6 |
| cfg_slow | input | 1 | 1 selects slow (half-rate) mode |
| cfg_feedback | input | 1 | 1 enables feedback of half the tap |
| cfg_in_mute | input | 1 | 1 zeroes the input term |
| sys_mute | input | 1 | Output mute; rising edge starts zero-fill |

## Verification
An output sample appears in `m_data` on the same rising edge that accepts its input, so the bench drives at a falling edge and compares at the next falling edge. A tap code takes effect one edge after it is driven, so the bench sets the configuration at least a cycle before streaming. The zero-fill starts one edge after `sys_mute` rises and lasts DEPTH cycles. The bench therefore waits DEPTH+4 cycles before it relies on cleared memory. It checks the zero output during the mute window itself.

// File: rtl/dl_pkg.sv
package dl_pkg;
  localparam int CODE_W = 3;

  typedef struct packed {
    logic              slow;
    logic              fb_en;
    logic              in_mute;
    logic [CODE_W-1:0] code;
  } dl_cfg_t;
endpackage

// File: rtl/dl_ram.sv
module dl_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 1536,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dl_tap_sel.sv
module dl_tap_sel #(
  parameter int NTAP = 6,
  parameter int CW   = 3,
  parameter int KW   = $clog2(NTAP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] code,
  output logic [KW-1:0] tap_k
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tap_k <= KW'(1);
    else if (int'(code) < NTAP) tap_k <= KW'(int'(code) + 1);
  end
endmodule

// File: rtl/dl_clear_seq.sv
module dl_clear_seq #(
  parameter int DEPTH = 1536,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sys_mute,
  output logic          start,
  output logic          busy,
  output logic [AW-1:0] addr
);
  logic mute_q;

  assign start = sys_mute && !mute_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mute_q <= 1'b0;
      busy   <= 1'b1;
      addr   <= '0;
    end else begin
      mute_q <= sys_mute;
      if (start) begin
        busy <= 1'b1;
        addr <= '0;
      end else if (busy) begin
        if (int'(addr) == DEPTH - 1) busy <= 1'b0;
        else addr <= addr + AW'(1);
      end
    end
  end
endmodule

// File: rtl/dl_mix.sv
module dl_mix #(
  parameter int W = 16
) (
  input  logic [W-1:0] in_s,
  input  logic [W-1:0] dly_s,
  input  logic         fb_en,
  input  logic         in_mute,
  output logic [W-1:0] out_s
);
  logic signed [W:0] a, b, s;

  always_comb begin
    a = in_mute ? '0 : {in_s[W-1], in_s};
    b = fb_en ? {dly_s[W-1], dly_s[W-1], dly_s[W-1:1]} : '0;
    s = a + b;
    if (s[W] != s[W-1]) out_s = s[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    else out_s = s[W-1:0];
  end
endmodule

// File: rtl/dl_delay_line.sv
module dl_delay_line #(
  parameter int W     = 16,
  parameter int DEPTH = 1536,
  parameter int NTAP  = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data,
  input  logic [2:0]   cfg_delay_code,
  input  logic         cfg_slow,
  input  logic         cfg_feedback,
  input  logic         cfg_in_mute,
  input  logic         sys_mute
);
  import dl_pkg::*;

  localparam int AW   = $clog2(DEPTH);
  localparam int STEP = DEPTH / NTAP;
  localparam int KW   = $clog2(NTAP + 1);

  dl_cfg_t       cfg;
  logic [KW-1:0] tap_q;
  logic [AW-1:0] tap_len, wr_ptr, rd_addr, clr_addr, ram_waddr;
  logic [W-1:0]  rd_data, mix_out, ram_wdata;
  logic          clr_busy, clr_start, phase_q;
  logic          accept, muted, take_slot, wr_sample, ram_we;

  assign cfg = '{slow: cfg_slow, fb_en: cfg_feedback, in_mute: cfg_in_mute, code: cfg_delay_code};

  dl_tap_sel #(.NTAP(NTAP), .CW(CODE_W), .KW(KW)) u_tap (
    .clk(clk), .rst_n(rst_n), .code(cfg.code), .tap_k(tap_q)
  );

  dl_clear_seq #(.DEPTH(DEPTH), .AW(AW)) u_clr (
    .clk(clk), .rst_n(rst_n), .sys_mute(sys_mute),
    .start(clr_start), .busy(clr_busy), .addr(clr_addr)
  );

  assign tap_len = AW'(int'(tap_q) * STEP);
  assign rd_addr = (wr_ptr >= tap_len) ? (wr_ptr - tap_len)
                                       : (wr_ptr + AW'(DEPTH) - tap_len);

  dl_mix #(.W(W)) u_mix (
    .in_s(s_data), .dly_s(rd_data), .fb_en(cfg.fb_en),
    .in_mute(cfg.in_mute), .out_s(mix_out)
  );

  assign s_ready   = !m_valid || m_ready;
  assign accept    = s_valid && s_ready;
  assign muted     = sys_mute || clr_busy;
  assign take_slot = !cfg.slow || !phase_q;
  assign wr_sample = accept && !muted && take_slot;

  assign ram_we    = clr_busy || wr_sample;
  assign ram_waddr = clr_busy ? clr_addr : wr_ptr;
  assign ram_wdata = clr_busy ? '0 : mix_out;

  dl_ram #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      phase_q <= 1'b0;
    end else if (clr_start) begin
      wr_ptr  <= '0;
      phase_q <= 1'b0;
    end else begin
      if (wr_sample) wr_ptr <= (int'(wr_ptr) == DEPTH - 1) ? '0 : wr_ptr + AW'(1);
      if (!cfg.slow) phase_q <= 1'b0;
      else if (accept && !muted) phase_q <= !phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else begin
      if (accept) m_valid <= 1'b1;
      else if (m_ready) m_valid <= 1'b0;
      if (accept) begin
        if (muted) m_data <= '0;
        else if (take_slot) m_data <= rd_data;
      end
    end
  end
endmodule

// File: rtl/dl_delay_line_chk.sv
module dl_delay_line_chk #(
  parameter int W     = 16,
  parameter int DEPTH = 1536,
  parameter int KW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_valid,
  input logic          s_ready,
  input logic          m_valid,
  input logic          m_ready,
  input logic [W-1:0]  m_data,
  input logic          sys_mute,
  input logic [2:0]    cfg_delay_code,
  input logic          clr_busy,
  input logic [KW-1:0] tap_q
);
  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= 0;
    else if (clr_busy) run_len <= run_len + 1;
    else run_len <= 0;
  end

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data))); // R8
  AST_ONE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> m_valid); // R8
  AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && !s_valid) |=> !m_valid); // R8
  AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && sys_mute) |=> (m_data == '0)); // R7
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && clr_busy) |=> (m_data == '0)); // R1
  AST_CLEAR_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_mute) |=> clr_busy); // R7
  AST_CLEAR_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clr_busy) |-> (run_len >= DEPTH)); // R7
  AST_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_delay_code > 3'd5) |=> $stable(tap_q)); // R4
  AST_TAP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_q >= KW'(1) && tap_q <= KW'(6))); // R4
endmodule

bind dl_delay_line dl_delay_line_chk #(.W(W), .DEPTH(DEPTH), .KW(KW)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .sys_mute(sys_mute),
  .cfg_delay_code(cfg_delay_code), .clr_busy(clr_busy), .tap_q(tap_q)
);

// File: tb/tb_dl_delay_line.sv
module tb_dl_delay_line;
  localparam int W     = 16;
  localparam int DEPTH = 1536;
  localparam int STEP  = DEPTH / 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         s_valid = 1'b0;
  logic         s_ready;
  logic [W-1:0] s_data = '0;
  logic         m_valid;
  logic         m_ready = 1'b1;
  logic [W-1:0] m_data;
  logic [2:0]   cfg_delay_code = 3'd0;
  logic         cfg_slow = 1'b0;
  logic         cfg_feedback = 1'b0;
  logic         cfg_in_mute = 1'b0;
  logic         sys_mute = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  // reference model state
  int mref [DEPTH];
  int mptr, mphase, mlast, mk;

  dl_delay_line #(.W(W), .DEPTH(DEPTH), .NTAP(6)) dut (.*);

  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) mref[i] = 0;
    mptr = 0; mphase = 0; mlast = 0;
  endtask

  // expected output for one unmuted sample
  function automatic int model_step(input int x);
    int rd, w, ex;
    if (!cfg_slow || mphase == 0) begin
      rd = mref[(mptr - mk * STEP + DEPTH) % DEPTH];
      w  = sat16((cfg_in_mute ? 0 : x) + (cfg_feedback ? (rd >>> 1) : 0));
      mref[mptr] = w;
      mptr = (mptr + 1) % DEPTH;
      mlast = rd;
      ex = rd;
    end else begin
      ex = mlast;
    end
    if (cfg_slow) mphase = 1 - mphase;
    return ex;
  endfunction

  // drive at a falling edge, compare at the next falling edge
  task automatic send(input int x, input string req, input bit mute_exp);
    int ex;
    s_valid = 1'b1;
    s_data  = W'(x);
    @(posedge clk);
    @(negedge clk);
    ex = mute_exp ? 0 : model_step(x);
    check(req, int'($signed(m_data)), ex);
    s_valid = 1'b0;
  endtask

  task automatic stream(input int n, input int base, input int stepv, input string req);
    for (int i = 0; i < n; i++) send(base + i * stepv, req, 1'b0);
  endtask

  task automatic do_clear();
    @(negedge clk);
    sys_mute = 1'b1;
    repeat (2) @(negedge clk);
    sys_mute = 1'b0;
    repeat (DEPTH + 4) @(negedge clk);
    model_reset();
  endtask

  task automatic set_code(input int c, input int k);
    cfg_delay_code = 3'(c);
    mk = k;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 m_valid after reset", int'(m_valid), 0);
    check("R8 s_ready after reset", int'(s_ready), 1);
    send(1234, "R1 output zero during sweep", 1'b1);
    repeat (DEPTH + 4) @(negedge clk);
    model_reset();
  endtask

  task automatic t_fast();
    set_code(0, 1);
    stream(300, 1, 1, "R2 fast K=1");
    do_clear();
    set_code(2, 3);
    stream(800, 100, 3, "R2 fast K=3");
  endtask

  task automatic t_slow();
    do_clear();
    cfg_slow = 1'b1;
    set_code(0, 1);
    stream(700, 5, 2, "R3 slow K=1");
    cfg_slow = 1'b0;
  endtask

  task automatic t_ignore();
    do_clear();
    set_code(1, 2);
    set_code(7, 2);
    stream(300, 7, 1, "R4 code 7 ignored");
    set_code(6, 2);
    stream(300, -50, 1, "R4 code 6 ignored");
  endtask

  task automatic t_feedback();
    do_clear();
    set_code(0, 1);
    cfg_feedback = 1'b1;
    send(1001, "R5 impulse", 1'b0);
    stream(800, 0, 0, "R5 echo decay");
    send(-7, "R5 negative", 1'b0);
    stream(520, 0, 0, "R5 negative floor");
  endtask

  task automatic t_saturate();
    do_clear();
    set_code(0, 1);
    cfg_feedback = 1'b1;
    stream(600, 30000, 0, "R9 positive clip");
    stream(600, -30000, 0, "R9 negative clip");
    cfg_feedback = 1'b0;
  endtask

  task automatic t_in_mute();
    do_clear();
    set_code(0, 1);
    stream(300, 40, 1, "R6 fill");
    cfg_in_mute = 1'b1;
    stream(300, 999, 1, "R6 input silenced");
    cfg_in_mute = 1'b0;
    stream(260, 1, 1, "R6 zeros replayed");
  endtask

  task automatic t_clear();
    set_code(0, 1);
    stream(300, 77, 1, "R7 fill");
    @(negedge clk);
    sys_mute = 1'b1;
    @(negedge clk);
    send(555, "R7 output zero while muted", 1'b1);
    sys_mute = 1'b0;
    repeat (DEPTH + 4) @(negedge clk);
    model_reset();
    stream(300, 3, 1, "R7 stale data gone");
  endtask

  task automatic t_backpressure();
    int held;
    set_code(0, 1);
    @(negedge clk);
    m_ready = 1'b0;
    send(11, "R8 first sample", 1'b0);
    held = int'($signed(m_data));
    s_valid = 1'b1;
    s_data  = W'(22);
    repeat (3) begin
      @(negedge clk);
      check("R8 s_ready low when stalled", int'(s_ready), 0);
      check("R8 m_data held", int'($signed(m_data)), held);
      check("R8 m_valid held", int'(m_valid), 1);
    end
    m_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8 second sample after release", int'($signed(m_data)), model_step(22));
    s_valid = 1'b0;
    @(negedge clk);
    check("R8 m_valid drops when drained", int'(m_valid), 0);
  endtask

  initial begin
    mk = 1;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fast();
    t_slow();
    t_ignore();
    t_feedback();
    t_saturate();
    t_in_mute();
    t_clear();
    t_backpressure();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule